// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block sits on the memory side of a 16-bit asynchronous parallel flash interface and turns the host's active-low chip, output and write enables into clean, clocked bus events. It samples all three enables on its own clock through two-flop synchronisers. A per-strobe glitch filter then accepts a new level only after it has held for a set number of samples. Each cycle is then classed as standby, output disable, read or write.

During a read the block drives the data bus from the array read-data input. When the identification high-voltage flag is present, it drives one of two fixed identification words instead. Write cycles are assembled from their edges. The address is taken when the second of chip enable and write enable goes low, and the data is taken when the first of them goes high. The completed command is handed to a downstream command interpreter as a one-clock strobe. A write during which output enable dropped low is discarded.

A power-state output reports standby when chip enable is high or when the bus has been idle for a programmable number of clocks. It never reports standby while an embedded program or erase is running.

Top module: `flash_bus_frontend`

## Requirements
- R1: `bus_op_o` reports the filtered cycle type: 0 when chip enable is high (standby); otherwise 2 for output enable low with write enable high (read), 3 for write enable low with output enable high (write), and 1 for any other combination (output disable).
- R2: In a read cycle without the identification flag, `data_oe_o` is 1 and `data_o` equals `rd_data_i`.
- R3: When output enable or chip enable is high, `data_oe_o` is 0 whatever the other enables are.
- R4: A write's command address is the value of `addr_i` when the later of chip enable and write enable goes low. Address changes after that point have no effect on it.
- R5: A write's command data is the value of `data_i` when the earlier of chip enable and write enable goes high. Data changes after that point have no effect on it.
- R6: If output enable goes low at any time while chip enable and write enable are both low, that write produces no command strobe.
- R7: A low pulse on an enable that is shorter than `GLITCH_CYC` clock samples is ignored and produces no command.
- R8: Each accepted write produces exactly one `cmd_valid_o` pulse one clock long, carrying `cmd_addr_o` and `cmd_data_o`.
- R9: In a read with `id_hv_i` high and address bit 1 low, `data_o` is `MFR_CODE` (default 0x0020) when address bit 0 is low, and `DEV_CODE` (default 0x0097) when it is high. With address bit 1 high, the normal array data is returned.
- R10: After `IDLE_CYC` clocks with no change on the synchronised enables or on the address, `standby_o` goes high, and a read already in progress keeps driving `data_o`.
- R11: An address change clears automatic standby at the next clock edge.
- R12: `standby_o` is 0 whenever `busy_i` is high, even with chip enable high.
- R13: With chip enable high and `busy_i` low, `standby_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Host address bus |
| id_hv_i | input | 1 | High voltage present on the identification address line |
| data_i | input | DW | Data bus input side |
| data_o | output | DW | Data bus output side |
| data_oe_o | output | 1 | Data bus drive enable |
| rd_data_i | input | DW | Array word at the current address |
| busy_i | input | 1 | Program or erase in progress |
| cmd_valid_o | output | 1 | One-clock command strobe |
| cmd_addr_o | output | AW | Latched command address |
| cmd_data_o | output | DW | Latched command data |
| bus_op_o | output | 2 | Decoded cycle type |
| standby_o | output | 1 | Standby power state |

## Verification
The assertions check, on every cycle, that the command strobe lasts one clock and follows a period with both enables low. They also check that the data bus is never driven with output or chip enable high, that busy always masks standby, that the identification words appear when selected, and that an address change ends automatic standby at once. The edge rules for the address and data, abort on output enable, glitch rejection and the idle timeout need ordered multi-step stimulus. Only the bench's directed and random scenarios can show these.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [1:0] {
    OP_STANDBY = 2'd0,
    OP_DISABLE = 2'd1,
    OP_READ    = 2'd2,
    OP_WRITE   = 2'd3
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic ce_n, input logic oe_n, input logic we_n);
    if (ce_n)               return OP_STANDBY;
    else if (!oe_n && we_n) return OP_READ;
    else if (oe_n && !we_n) return OP_WRITE;
    else                    return OP_DISABLE;
  endfunction

endpackage

// File: rtl/flash_fe_strobe_filter.sv
module flash_fe_strobe_filter #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == CW'(GLITCH_CYC - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/flash_fe_write_capture.sv
module flash_fe_write_capture #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_f_i,
  input  logic          oe_f_i,
  input  logic          we_f_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  logic          in_wr_q, wr_ok_q;
  logic [AW-1:0] addr_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_wr_q     <= 1'b0;
      wr_ok_q     <= 1'b0;
      addr_lat_q  <= '0;
      cmd_valid_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (!in_wr_q) begin
        // second falling enable opens the cycle and fixes the address
        if (!ce_f_i && !we_f_i) begin
          in_wr_q    <= 1'b1;
          wr_ok_q    <= oe_f_i;
          addr_lat_q <= addr_i;
        end
      end else if (ce_f_i || we_f_i) begin
        // first rising enable closes it and fixes the data
        in_wr_q <= 1'b0;
        if (wr_ok_q && oe_f_i) begin
          cmd_valid_o <= 1'b1;
          cmd_addr_o  <= addr_lat_q;
          cmd_data_o  <= data_i;
        end
      end else if (!oe_f_i) begin
        wr_ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_fe_idle_timer.sv
module flash_fe_idle_timer #(
  parameter int AW       = 16,
  parameter int IDLE_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    strb_i,
  input  logic [AW-1:0] addr_i,
  output logic          auto_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);

  logic [2:0]    strb_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          act;

  assign act = (strb_i != strb_q) || (addr_i != addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 3'b111;
      addr_q <= '0;
      cnt_q  <= '0;
      auto_o <= 1'b0;
    end else begin
      strb_q <= strb_i;
      addr_q <= addr_i;
      if (act) begin
        cnt_q  <= '0;
        auto_o <= 1'b0;
      end else if (!auto_o) begin
        if (cnt_q == CW'(IDLE_CYC - 1)) auto_o <= 1'b1;
        else                            cnt_q  <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          GLITCH_CYC = 3,
  parameter int          IDLE_CYC   = 8,
  parameter logic [15:0] MFR_CODE   = 16'h0020,
  parameter logic [15:0] DEV_CODE   = 16'h0097
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          id_hv_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] rd_data_i,
  input  logic          busy_i,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic [1:0]    bus_op_o,
  output logic          standby_o
);
  localparam int NSTRB = 3;

  logic [NSTRB-1:0] strb_raw, strb_sync, strb_filt;
  logic             ce_f, oe_f, we_f, auto_stby, id_sel;
  bus_op_e          op;

  assign strb_raw = {we_ni, oe_ni, ce_ni};

  for (genvar g = 0; g < NSTRB; g++) begin : g_strb
    flash_fe_strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (strb_raw[g]),
      .sync_o (strb_sync[g]),
      .filt_o (strb_filt[g])
    );
  end

  assign ce_f = strb_filt[0];
  assign oe_f = strb_filt[1];
  assign we_f = strb_filt[2];

  assign op       = decode_op(ce_f, oe_f, we_f);
  assign bus_op_o = op;

  flash_fe_write_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_f_i      (ce_f),
    .oe_f_i      (oe_f),
    .we_f_i      (we_f),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o)
  );

  flash_fe_idle_timer #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (strb_sync),
    .addr_i (addr_i),
    .auto_o (auto_stby)
  );

  // identification words replace array data under the high-voltage flag
  assign id_sel    = id_hv_i && !addr_i[1];
  assign data_oe_o = (op == OP_READ);
  always_comb begin
    if (id_sel) data_o = addr_i[0] ? DW'(DEV_CODE) : DW'(MFR_CODE);
    else        data_o = rd_data_i;
  end

  assign standby_o = !busy_i && (ce_f || auto_stby);
endmodule

// File: rtl/flash_bus_frontend_chk.sv
module flash_bus_frontend_chk #(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h0097
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_f,
  input logic          oe_f,
  input logic          we_f,
  input logic          auto_stby,
  input logic [AW-1:0] addr_i,
  input logic          id_hv_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic          busy_i,
  input logic          cmd_valid_o,
  input logic          standby_o
);
  assert_cmd_one_clock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_cmd_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(!ce_f && !we_f, 2));

  assert_no_drive_oe_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_f || ce_f) |-> !data_oe_o);

  assert_busy_no_standby_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !standby_o);

  assert_mfr_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && id_hv_i && !addr_i[1] && !addr_i[0]) |-> (data_o == DW'(MFR_CODE)));

  assert_dev_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && id_hv_i && !addr_i[1] && addr_i[0]) |-> (data_o == DW'(DEV_CODE)));

  assert_addr_wakes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != $past(addr_i)) |=> !auto_stby);
endmodule

bind flash_bus_frontend flash_bus_frontend_chk #(
  .AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_f        (ce_f),
  .oe_f        (oe_f),
  .we_f        (we_f),
  .auto_stby   (auto_stby),
  .addr_i      (addr_i),
  .id_hv_i     (id_hv_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .busy_i      (busy_i),
  .cmd_valid_o (cmd_valid_o),
  .standby_o   (standby_o)
);

// File: tb/flash_bus_frontend_bench.sv
module flash_bus_frontend_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          id_hv = 1'b0, busy = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] data_o, rd_data, cmd_addr, cmd_data;
  logic          data_oe, cmd_valid, standby;
  logic [1:0]    bus_op;

  int checks = 0, failures = 0, cmd_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] arr_word(input logic [AW-1:0] a);
    return a ^ 16'h5A5A;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic hv);
    if (hv && !a[1]) return a[0] ? 16'h0097 : 16'h0020;
    return arr_word(a);
  endfunction

  assign rd_data = arr_word(addr);

  flash_bus_frontend u_flash_bus_frontend (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .addr_i(addr), .id_hv_i(id_hv), .data_i(din), .data_o(data_o), .data_oe_o(data_oe),
    .rd_data_i(rd_data), .busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .bus_op_o(bus_op), .standby_o(standby)
  );

  always @(negedge clk) if (rst_ni && cmd_valid) begin
    cmd_cnt++;
    last_addr = cmd_addr;
    last_data = cmd_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0 = cmd_cnt;
    addr = a; din = d; oe_ni = 1'b1; ce_ni = 1'b0;
    wait_n(8); we_ni = 1'b0;
    wait_n(8);
    chk(bus_op == 2'd3, "R1 write op", bus_op, 3);
    we_ni = 1'b1;
    wait_n(8); ce_ni = 1'b1;
    wait_n(8);
    chk(cmd_cnt == c0 + 1, "R8 one strobe", cmd_cnt - c0, 1);
    chk(last_addr == a && last_data == d, "R4 R5 command", {last_addr, last_data}, {a, d});
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic hv);
    addr = a; id_hv = hv; we_ni = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0;
    wait_n(10);
    chk(data_oe && data_o == exp_read(a, hv), "R2 R9 read data", data_o, exp_read(a, hv));
    oe_ni = 1'b1; ce_ni = 1'b1; id_hv = 1'b0;
    wait_n(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'd20240611));
    wait_n(4); rst_ni = 1'b1; wait_n(2);

    chk(!data_oe && bus_op == 2'd0 && standby && cmd_cnt == 0, "R13 reset state",
        {data_oe, bus_op, standby}, 3'b001);

    // R2 plain read
    do_read(16'h1234, 1'b0);
    // R9 identification words and fallback with bit 1 set
    do_read(16'h0000, 1'b1);
    do_read(16'hFF01, 1'b1);
    do_read(16'h0002, 1'b1);

    // R3 output disable and standby
    ce_ni = 1'b0; oe_ni = 1'b1; we_ni = 1'b1; wait_n(10);
    chk(!data_oe && bus_op == 2'd1, "R3 R1 output disable", {data_oe, bus_op}, 1);
    ce_ni = 1'b1; oe_ni = 1'b0; wait_n(10);
    chk(!data_oe && bus_op == 2'd0 && standby, "R3 R13 standby", {data_oe, bus_op, standby}, 1);
    oe_ni = 1'b1; wait_n(4);

    // R12 busy masks standby
    busy = 1'b1; wait_n(2);
    chk(!standby, "R12 busy", standby, 0);
    busy = 1'b0; wait_n(2);

    do_write(16'h0555, 16'h00AA);

    // R4 R5 edge ordering: CE falls first, WE falls last; CE rises first
    c0 = cmd_cnt;
    addr = 16'h1111; din = 16'h0BAD; ce_ni = 1'b0; wait_n(8);
    addr = 16'h2AAA; wait_n(8);
    we_ni = 1'b0; wait_n(8);
    addr = 16'h3333; din = 16'h0055; wait_n(8);
    ce_ni = 1'b1; wait_n(8);
    din = 16'hDEAD; we_ni = 1'b1; wait_n(8);
    chk(cmd_cnt == c0 + 1 && last_addr == 16'h2AAA, "R4 later fall address", last_addr, 16'h2AAA);
    chk(last_data == 16'h0055, "R5 earlier rise data", last_data, 16'h0055);

    // R6 OE low inside write cancels
    c0 = cmd_cnt;
    ce_ni = 1'b0; we_ni = 1'b0; wait_n(10);
    oe_ni = 1'b0; wait_n(8); oe_ni = 1'b1; wait_n(8);
    we_ni = 1'b1; wait_n(8); ce_ni = 1'b1; wait_n(8);
    chk(cmd_cnt == c0, "R6 oe abort", cmd_cnt - c0, 0);

    // R7 short WE pulse ignored
    c0 = cmd_cnt;
    ce_ni = 1'b0; wait_n(10);
    we_ni = 1'b0; wait_n(1); we_ni = 1'b1; wait_n(15);
    chk(cmd_cnt == c0, "R7 glitch", cmd_cnt - c0, 0);
    ce_ni = 1'b1; wait_n(10);

    // R10 auto standby with read in progress; R11 wake on address change
    addr = 16'h0040; ce_ni = 1'b0; oe_ni = 1'b0; wait_n(30);
    chk(standby && data_oe && data_o == arr_word(16'h0040), "R10 auto standby read",
        {standby, data_oe}, 2'b11);
    addr = 16'h0041; wait_n(1);
    chk(!standby, "R11 wake", standby, 0);
    oe_ni = 1'b1; ce_ni = 1'b1; wait_n(8);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(a, d);
      else do_read(a, 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule